// File: doc/BRIEF.md
# External Interrupt Controller with Grouped Outputs

This block accepts 28 asynchronous external interrupt lines (numbered 0 to 27) and decides, line by line, which activity counts as an interrupt event. The choices are a low level, a high level, a falling edge, a rising edge or either edge. Each line is brought into the clock domain by a two-flop synchroniser. A further flop keeps the previous synchronised sample, so that edges can be found. Every detected event sets a sticky pending bit. Software clears a pending bit by writing a one to it.

A per-line mask then gates the pending bits. The unmasked pending bits are ORed into four group outputs of unequal width, which feed a primary interrupt controller. A handler that sees a group output reads the pending and mask registers to find the line that caused it.

Software reaches four word registers through a simple bus with a write strobe, a 2-bit register select and a combinational read path. The registers are the low configuration word, the high configuration word, the mask and the pending word. The block holds no state machine. Its sequential state is the synchroniser chain and the four registers.

Top module: `extint_ctrl`

## Requirements
- R1: Register select 2 is the mask register. Bit i masks line i when it is 1. Bits 27:0 are read/write and bits 31:28 read as 0. After reset the mask holds 0x0FFFFFFF, so every line is masked.
- R2: A masked line never drives a group output. Its pending bit is still set by events and can be read back while the line is masked.
- R3: Register select 3 is the pending register, and bit i belongs to line i. Writing a 1 to a bit clears it. Writing a 0 leaves the bit unchanged.
- R4: When an event on a line falls in the same cycle as a write-one-to-clear of that line's pending bit, the bit stays set. A pending bit is never set without an event.
- R5: Lines 0 to 15 are configured through register select 0 and lines 16 to 27 through register select 1. A line with local index j = i mod 16 uses the 3-bit field at bit offset (j/2)*4, so lines 2k and 2k+1 share one field. The unused bits read as 0: bit 3 of each nibble, and bits 31:24 of select 1. All fields reset to 0.
- R6: Field code 000 means the low level is active and code 001 means the high level is active. In a level mode the pending bit is set on every cycle that the active level is present. A clear therefore has no lasting effect while the line is still active.
- R7: Field code 01x means falling edge, 10x means rising edge and 11x means both edges (bit 0 is ignored). The return of the line to its idle level sets nothing, except in the both-edges mode.
- R8: Group outputs 0, 1, 2 and 3 are the OR of (pending AND NOT mask) over lines 0–3, 4–11, 12–19 and 20–27.
- R9: If an input changes between clock edges, its pending bit shows the event after the third rising edge that follows the change, and not after the second.
- R10: While reset is asserted, pending reads 0, both configuration words read 0 and all group outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lines_i | input | 28 | Asynchronous external interrupt lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 config low, 1 config high, 2 mask, 3 pending |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_grp_o | output | 4 | Grouped interrupt outputs to the primary controller |

## Verification
The hardest case to reach is an event that coincides with a clear in the same cycle. The bench gets there by holding a line at its active level in a level mode and then issuing a clear, so that the event and the clear meet on the same edge. Only a pending bit that reads back set after the clear shows that the set took priority.

The shared configuration fields are reached by two sweeps. The first goes over every line and all eight field codes, with every field written alike. The second writes a rising-edge code into one line's field only, among high-level fields. The line can then fire only if its field is decoded at the right place.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int NUM_LINES     = 28;
    localparam int LINES_PER_CFG = 16;
    localparam int FIELD_W       = 3;
    localparam int FIELD_STRIDE  = 4;
    localparam int NUM_GROUPS    = 4;
    localparam int DATA_W        = 32;
    localparam int HI_LINES      = NUM_LINES - LINES_PER_CFG;
    localparam int LO_FIELDS     = LINES_PER_CFG / 2;
    localparam int HI_FIELDS     = (HI_LINES + 1) / 2;

    typedef enum logic [1:0] {
        REG_CFG_LO = 2'd0,
        REG_CFG_HI = 2'd1,
        REG_MASK   = 2'd2,
        REG_PEND   = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        TRIG_LOW,
        TRIG_HIGH,
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH
    } trig_kind_e;

    function automatic trig_kind_e decode_trig(input logic [FIELD_W-1:0] f);
        trig_kind_e k;
        case (f[2:1])
            2'b00:   k = f[0] ? TRIG_HIGH : TRIG_LOW;
            2'b01:   k = TRIG_FALL;
            2'b10:   k = TRIG_RISE;
            default: k = TRIG_BOTH;
        endcase
        return k;
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(input int nfields);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < nfields; k++) begin
            m[k*FIELD_STRIDE +: FIELD_W] = '1;
        end
        return m;
    endfunction

    function automatic int group_first(input int g);
        return (g == 0) ? 0 : 4 + (g - 1) * 8;
    endfunction

    function automatic int group_last(input int g);
        return (g == 0) ? 3 : 11 + (g - 1) * 8;
    endfunction

    function automatic logic [NUM_LINES-1:0] group_lines(input int g);
        logic [NUM_LINES-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (i >= group_first(g) && i <= group_last(g)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
(
    input  logic               cur_i,
    input  logic               prev_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               event_o
);

    trig_kind_e kind;

    always_comb begin
        kind = decode_trig(field_i);
        unique case (kind)
            TRIG_LOW:  event_o = ~cur_i;
            TRIG_HIGH: event_o = cur_i;
            TRIG_FALL: event_o = prev_i & ~cur_i;
            TRIG_RISE: event_o = cur_i & ~prev_i;
            TRIG_BOTH: event_o = cur_i ^ prev_i;
            default:   event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_i,
    input  logic [1:0]           bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    input  logic [NUM_LINES-1:0] evt_i,
    output logic [DATA_W-1:0]    cfg_lo_o,
    output logic [DATA_W-1:0]    cfg_hi_o,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [DATA_W-1:0]    rdata_o
);

    localparam logic [DATA_W-1:0] LO_WMASK = field_mask(LO_FIELDS);
    localparam logic [DATA_W-1:0] HI_WMASK = field_mask(HI_FIELDS);

    logic [DATA_W-1:0]    cfg_lo_q;
    logic [DATA_W-1:0]    cfg_hi_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] clr_bits;
    logic [NUM_LINES-1:0] pend_next;
    reg_sel_e             sel;

    always_comb begin
        sel       = reg_sel_e'(bus_addr_i);
        clr_bits  = (bus_wr_i && sel == REG_PEND) ? bus_wdata_i[NUM_LINES-1:0] : '0;
        pend_next = (pend_q & ~clr_bits) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '1;
            pend_q   <= '0;
        end else begin
            if (bus_wr_i && sel == REG_CFG_LO) cfg_lo_q <= bus_wdata_i & LO_WMASK;
            if (bus_wr_i && sel == REG_CFG_HI) cfg_hi_q <= bus_wdata_i & HI_WMASK;
            if (bus_wr_i && sel == REG_MASK)   mask_q   <= bus_wdata_i[NUM_LINES-1:0];
            pend_q <= pend_next;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CFG_LO: rdata_o = cfg_lo_q;
            REG_CFG_HI: rdata_o = cfg_hi_q;
            REG_MASK:   rdata_o = {{(DATA_W-NUM_LINES){1'b0}}, mask_q};
            REG_PEND:   rdata_o = {{(DATA_W-NUM_LINES){1'b0}}, pend_q};
            default:    rdata_o = '0;
        endcase
    end

    assign cfg_lo_o = cfg_lo_q;
    assign cfg_hi_o = cfg_hi_q;
    assign mask_o   = mask_q;
    assign pend_o   = pend_q;

    // A written one clears the bit unless an event arrives with it
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 2'd3) |=> ((pend_q & $past(bus_wdata_i[NUM_LINES-1:0] & ~evt_i)) == '0));

    // Bits not written with one are kept
    assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((~pend_q & $past(pend_q & ~clr_bits)) == '0));

    // An event sets its bit even under a simultaneous clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // No bit becomes pending without an event
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0));

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  ext_lines_i,
    input  logic                  bus_wr_i,
    input  logic [1:0]            bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic [NUM_GROUPS-1:0] irq_grp_o
);

    logic [NUM_LINES-1:0] cur;
    logic [NUM_LINES-1:0] prv;
    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] active;
    logic [DATA_W-1:0]    cfg_lo;
    logic [DATA_W-1:0]    cfg_hi;

    extint_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_lines_i),
        .cur_o  (cur),
        .prev_o (prv)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int LOC = i % LINES_PER_CFG;
        localparam int OFF = (LOC / 2) * FIELD_STRIDE;
        logic [FIELD_W-1:0] fld;
        if (i < LINES_PER_CFG) begin : g_lo
            assign fld = cfg_lo[OFF +: FIELD_W];
        end else begin : g_hi
            assign fld = cfg_hi[OFF +: FIELD_W];
        end
        extint_detect u_det (
            .cur_i  (cur[i]),
            .prev_i (prv[i]),
            .field_i(fld),
            .event_o(evt[i])
        );
    end

    extint_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .bus_wdata_i(bus_wdata_i),
        .evt_i      (evt),
        .cfg_lo_o   (cfg_lo),
        .cfg_hi_o   (cfg_hi),
        .mask_o     (mask),
        .pend_o     (pend),
        .rdata_o    (bus_rdata_o)
    );

    assign active = pend & ~mask;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [NUM_LINES-1:0] GMASK = group_lines(g);
        assign irq_grp_o[g] = |(active & GMASK);
    end

    // Fully masked means no group output at all
    assert_all_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> (irq_grp_o == '0));

    // No group output without some pending bit
    assert_grp_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq_grp_o == '0));

endmodule

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;

    localparam int NL = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_grp;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    extint_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_lines_i(lines),
        .bus_wr_i   (bus_wr),
        .bus_addr_i (bus_addr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .irq_grp_o  (irq_grp)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int grp_of(input int l);
        return (l < 4) ? 0 : (l < 12) ? 1 : (l < 20) ? 2 : 3;
    endfunction

    function automatic logic [31:0] rep(input logic [2:0] code, input int nf);
        logic [31:0] v = '0;
        for (int k = 0; k < nf; k++) v[k*4 +: 3] = code;
        return v;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] bit_l;
        logic        idle;
        tick(2);
        // R10 / R1 reset values while reset held
        rd(2'd0, d); chk("R10", "cfg lo in reset", d, 32'h0);
        rd(2'd1, d); chk("R10", "cfg hi in reset", d, 32'h0);
        rd(2'd3, d); chk("R10", "pending in reset", d, 32'h0);
        rd(2'd2, d); chk("R1", "mask in reset", d, 32'h0FFFFFFF);
        chk("R10", "irq in reset", {28'h0, irq_grp}, 32'h0);
        rst_n = 1'b1;
        tick(2);

        // R1 mask read/write
        wr(2'd2, 32'hFFFFFFFF); rd(2'd2, d); chk("R1", "mask all ones", d, 32'h0FFFFFFF);
        wr(2'd2, 32'h12345678); rd(2'd2, d); chk("R1", "mask pattern", d, 32'h02345678);
        // R5 unused config bits
        wr(2'd0, 32'hFFFFFFFF); rd(2'd0, d); chk("R5", "cfg lo writable bits", d, 32'h77777777);
        wr(2'd1, 32'hFFFFFFFF); rd(2'd1, d); chk("R5", "cfg hi writable bits", d, 32'h00777777);

        // Sweep: every line, every field code
        for (int l = 0; l < NL; l++) begin
            for (int c = 0; c < 8; c++) begin
                bit_l = 32'h1 << l;
                idle = (c == 0 || c == 2 || c == 3);
                lines = {NL{idle}};
                wr(2'd0, rep(3'(c), 8));
                wr(2'd1, rep(3'(c), 6));
                wr(2'd2, ~bit_l & 32'h0FFFFFFF);
                tick(4);
                wr(2'd3, 32'h0FFFFFFF);
                rd(2'd3, d); chk("R3", "cleared before test", d, 32'h0);
                lines[l] = ~idle;
                tick(2);
                rd(2'd3, d); chk("R9", "not yet after two edges", d, 32'h0);
                tick(1);
                rd(2'd3, d); chk("R9", "set after three edges", d, bit_l);
                chk("R8", "group output", {28'h0, irq_grp}, 32'h1 << grp_of(l));
                wr(2'd3, 32'h0);
                rd(2'd3, d); chk("R3", "write zero keeps", d, bit_l);
                wr(2'd2, 32'hFFFFFFFF);
                chk("R2", "masked irq quiet", {28'h0, irq_grp}, 32'h0);
                rd(2'd3, d); chk("R2", "pending kept while masked", d, bit_l);
                wr(2'd2, ~bit_l & 32'h0FFFFFFF);
                wr(2'd3, bit_l);
                rd(2'd3, d);
                if (c < 2) chk("R4", "level re-set wins over clear (R6)", d, bit_l);
                else       chk("R7", "edge clear sticks", d, 32'h0);
                lines[l] = idle;
                tick(4);
                rd(2'd3, d);
                if (c < 2)       chk("R6", "level bit stays after release", d, bit_l);
                else if (c >= 6) chk("R7", "both edges fires on release", d, bit_l);
                else             chk("R7", "single edge ignores release", d, 32'h0);
                wr(2'd3, bit_l);
                rd(2'd3, d); chk("R3", "final clear", d, 32'h0);
            end
        end

        // R5 field placement: one line rising, all other fields high level
        for (int l = 0; l < NL; l++) begin
            logic [31:0] lo_v;
            logic [31:0] hi_v;
            int off;
            bit_l = 32'h1 << l;
            off = ((l % 16) / 2) * 4;
            lo_v = rep(3'd1, 8);
            hi_v = rep(3'd1, 6);
            if (l < 16) lo_v[off +: 3] = 3'd4; else hi_v[off +: 3] = 3'd4;
            lines = '0;
            wr(2'd0, lo_v);
            wr(2'd1, hi_v);
            wr(2'd2, 32'h0);
            rd(l < 16 ? 2'd0 : 2'd1, d); chk("R5", "field readback", d, l < 16 ? lo_v : hi_v);
            tick(4);
            wr(2'd3, 32'h0FFFFFFF);
            lines[l] = 1'b1;
            tick(3);
            rd(2'd3, d); chk("R5", "placed field fires once", d, bit_l);
            wr(2'd3, 32'h0FFFFFFF);
            tick(1);
            rd(2'd3, d); chk("R5", "rising mode no level refire", d, 32'h0);
            lines[l] = 1'b0;
            tick(4);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule